// File: doc/BRIEF.md
# Register Rename Map with Free Physical Tag Pool

This block is the renaming step of an out-of-order core. Instructions name up to 32 architectural registers plus one condition-flags register. The block translates those names into tags of a larger physical register pool, which has 180 tags by default. For each instruction it returns the physical tags of its two sources. It also hands the destination a tag taken from a pool of free tags, together with the tag that destination was mapped to before. That previous tag travels with the instruction so it can be released later.

A reorder buffer, outside this block, commits instructions strictly in program order. Each commit updates a committed copy of the map and puts the released tag back into the pool. A flush discards all speculative work: the speculative map becomes the committed map, and every tag handed out since the last commit goes back to the pool in the order it was first issued.

Architectural index 0 is a constant-zero register and is never remapped. Index 32 names the flags register, which is renamed exactly like a general register.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural index i (0 to 32) maps to physical tag i, and `ren_ready` is high.
- R2: A rename with `ren_dst_we` high and a nonzero destination returns the head of the free pool on `ren_pdst`. It returns the destination's current mapping on `ren_pold`. After reset the pool hands out tags 33, 34, 35 and so on, in ascending order.
- R3: Once such a rename is accepted, sources naming that destination read the new tag. Two renames of the same register receive different tags.
- R4: Index 0 always reads tag 0. A rename whose destination is 0, or whose `ren_dst_we` is low, allocates nothing and returns 0 on both `ren_pdst` and `ren_pold`.
- R5: Index 32 (the flags register) is mapped, allocated and restored like any other nonzero index.
- R6: When the pool is empty, `ren_ready` is low for an allocating rename. A valid rename presented in that state changes neither the map nor the pool.
- R7: A commit with `cmt_we` high and a nonzero `cmt_dst` records `cmt_pdst` in the committed map. It also appends `cmt_pold` to the tail of the pool, so that tag is handed out after every tag already in the pool.
- R8: A flush makes the speculative map equal the committed map. A commit in the same cycle is included in that committed map. Renames after the flush are handed, in original order, the tags that uncommitted instructions had received.
- R9: A flush takes priority over a rename presented in the same cycle; that rename has no effect.
- R10: A commit with `cmt_we` low, or with `cmt_dst` equal to 0, changes neither the committed map nor the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore the speculative map from the committed map |
| ren_valid | input | 1 | A rename is presented this cycle |
| ren_src1 | input | 6 | First source architectural index (32 = flags) |
| ren_src2 | input | 6 | Second source architectural index (32 = flags) |
| ren_dst_we | input | 1 | The instruction writes a destination |
| ren_dst | input | 6 | Destination architectural index (32 = flags) |
| ren_ready | output | 1 | Rename can be accepted |
| ren_psrc1 | output | 8 | Physical tag of the first source |
| ren_psrc2 | output | 8 | Physical tag of the second source |
| ren_pdst | output | 8 | Newly allocated destination tag |
| ren_pold | output | 8 | Previous tag of the destination |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_we | input | 1 | The committing instruction wrote a destination |
| cmt_dst | input | 6 | Committing destination architectural index |
| cmt_pdst | input | 8 | Tag the committing instruction was given |
| cmt_pold | input | 8 | Tag to release to the pool |

## Verification
The assertions check the properties that hold on every cycle and need no history:
- the zero register always reads tag 0, and a non-allocating rename returns zero tags;
- stalls happen only for allocating renames;
- a granted tag is nonzero, inside the pool, and different from the tag it replaces;
- consecutive grants without an intervening flush differ;
- the pool is never empty right after a flush.

The bench scenarios are needed for the behaviours that depend on order and history:
- the exact tag sequence of the FIFO pool;
- tags released at commit being reused only after the tags already in the pool;
- recovery of the right tags and mappings after a flush, including a flush that coincides with a commit or a rename;
- the state being left untouched by a stalled rename or by a non-writing commit.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int ARCH = 32,
  parameter int PHYS = 180,
  localparam int AW = $clog2(ARCH + 1),
  localparam int TW = $clog2(PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic          ren_dst_we,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [TW-1:0] ren_psrc1,
  output logic [TW-1:0] ren_psrc2,
  output logic [TW-1:0] ren_pdst,
  output logic [TW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_we,
  input  logic [AW-1:0] cmt_dst,
  input  logic [TW-1:0] cmt_pdst,
  input  logic [TW-1:0] cmt_pold
);
  localparam int NMAP  = ARCH + 1;
  localparam int NFREE = PHYS - NMAP;
  localparam int CW    = $clog2(PHYS + 1);

  logic [TW-1:0] smap   [NMAP];
  logic [TW-1:0] cmap   [NMAP];
  logic [TW-1:0] cmap_n [NMAP];
  logic [TW-1:0] pool   [PHYS];
  logic [TW-1:0] head, chead, tail;
  logic [CW-1:0] cnt;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] p);
    return (p == TW'(PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  wire alloc = ren_dst_we && ren_dst != '0 && int'(ren_dst) < NMAP;
  wire fire  = ren_valid && alloc && cnt != '0 && !flush;
  wire cfree = cmt_valid && cmt_we && cmt_dst != '0 && int'(cmt_dst) < NMAP;

  assign ren_ready = !alloc || cnt != '0;
  assign ren_psrc1 = smap[ren_src1];
  assign ren_psrc2 = smap[ren_src2];
  assign ren_pdst  = alloc ? pool[head] : '0;
  assign ren_pold  = alloc ? smap[ren_dst] : '0;

  always_comb
    for (int i = 0; i < NMAP; i++)
      cmap_n[i] = (cfree && int'(cmt_dst) == i) ? cmt_pdst : cmap[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMAP; i++) begin
        smap[i] <= TW'(i);
        cmap[i] <= TW'(i);
      end
      for (int k = 0; k < PHYS; k++)
        pool[k] <= (k < NFREE) ? TW'(k + NMAP) : '0;
      head  <= '0;
      chead <= '0;
      tail  <= TW'(NFREE);
      cnt   <= CW'(NFREE);
    end else begin
      for (int i = 0; i < NMAP; i++) cmap[i] <= cmap_n[i];
      if (cfree) begin
        pool[tail] <= cmt_pold;
        tail  <= nxt(tail);
        chead <= nxt(chead);
      end
      if (flush) begin
        for (int i = 0; i < NMAP; i++) smap[i] <= cmap_n[i];
        head <= cfree ? nxt(chead) : chead;
        cnt  <= CW'(NFREE);
      end else begin
        if (fire) begin
          smap[ren_dst] <= pool[head];
          head <= nxt(head);
        end
        cnt <= cnt - CW'(fire) + CW'(cfree);
      end
    end
  end
endmodule

// File: rtl/rename_map_sva.sv
module rename_map_sva #(
  parameter int ARCH = 32,
  parameter int PHYS = 180,
  localparam int AW = $clog2(ARCH + 1),
  localparam int TW = $clog2(PHYS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          ren_valid,
  input logic [AW-1:0] ren_src1,
  input logic [AW-1:0] ren_src2,
  input logic          ren_dst_we,
  input logic [AW-1:0] ren_dst,
  input logic          ren_ready,
  input logic [TW-1:0] ren_psrc1,
  input logic [TW-1:0] ren_psrc2,
  input logic [TW-1:0] ren_pdst,
  input logic [TW-1:0] ren_pold
);
  wire grant = ren_valid && ren_ready && ren_dst_we && ren_dst != '0 && !flush;

  a_r4_zero_src1: assert property (@(posedge clk) disable iff (!rst_n)
    ren_src1 == '0 |-> ren_psrc1 == '0);
  a_r4_zero_src2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_src2 == '0 |-> ren_psrc2 == '0);
  a_r4_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_dst_we || ren_dst == '0) |-> (ren_pdst == '0 && ren_pold == '0));
  a_r6_stall_only_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_ready |-> (ren_dst_we && ren_dst != '0));
  a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (ren_pdst != '0 && int'(ren_pdst) < PHYS));
  a_r3_new_differs_old: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ren_pdst != ren_pold);
  a_r3_consecutive_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (!grant || ren_pdst != $past(ren_pdst)));
  a_r8_ready_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ren_ready);
endmodule

bind rename_map rename_map_sva #(.ARCH(ARCH), .PHYS(PHYS)) u_sva (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ren_valid(ren_valid),
  .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst_we(ren_dst_we),
  .ren_dst(ren_dst), .ren_ready(ren_ready), .ren_psrc1(ren_psrc1),
  .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst), .ren_pold(ren_pold)
);

// File: tb/rename_map_test.sv
`timescale 1ns/1ps
module rename_map_test;
  localparam int ARCH = 32;
  localparam int PHYS = 180;
  localparam int NMAP = ARCH + 1;
  localparam int NFREE = PHYS - NMAP;

  logic clk = 0, rst_n = 0, flush = 0;
  logic ren_valid = 0, ren_dst_we = 0;
  logic [5:0] ren_src1 = 0, ren_src2 = 0, ren_dst = 0;
  logic ren_ready;
  logic [7:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic cmt_valid = 0, cmt_we = 0;
  logic [5:0] cmt_dst = 0;
  logic [7:0] cmt_pdst = 0, cmt_pold = 0;

  rename_map #(.ARCH(ARCH), .PHYS(PHYS)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ren_valid(ren_valid),
    .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst_we(ren_dst_we),
    .ren_dst(ren_dst), .ren_ready(ren_ready), .ren_psrc1(ren_psrc1),
    .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .cmt_valid(cmt_valid), .cmt_we(cmt_we), .cmt_dst(cmt_dst),
    .cmt_pdst(cmt_pdst), .cmt_pold(cmt_pold));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  int msmap[NMAP], mcmap[NMAP], mpool[PHYS];
  int mhead, mchead, mtail, mcnt;
  int rob_d[256], rob_p[256], rob_o[256];
  int rd = 0, wr = 0;

  function automatic int inc(int p);
    return (p == PHYS - 1) ? 0 : p + 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NMAP; i++) begin msmap[i] = i; mcmap[i] = i; end
    for (int k = 0; k < PHYS; k++) mpool[k] = (k < NFREE) ? k + NMAP : 0;
    mhead = 0; mchead = 0; mtail = NFREE; mcnt = NFREE; rd = 0; wr = 0;
  endtask

  // one cycle: drive, check combinational outputs, clock, update model
  task automatic step(bit rv, int s1, int s2, bit dwe, int d, bit cv,
                      bit noise, bit fl, string req);
    bit alloc, fire, cfree;
    int t;
    @(negedge clk);
    ren_valid = rv; ren_src1 = 6'(s1); ren_src2 = 6'(s2);
    ren_dst_we = dwe; ren_dst = 6'(d); flush = fl;
    cfree = cv && rd != wr;
    if (cfree) begin
      cmt_valid = 1; cmt_we = 1; cmt_dst = 6'(rob_d[rd % 256]);
      cmt_pdst = 8'(rob_p[rd % 256]); cmt_pold = 8'(rob_o[rd % 256]);
    end else if (noise) begin
      cmt_valid = 1; cmt_we = 1'($urandom % 2);
      cmt_dst = cmt_we ? 6'd0 : 6'($urandom % NMAP);
      cmt_pdst = 8'($urandom % PHYS); cmt_pold = 8'($urandom % PHYS);
    end else begin
      cmt_valid = 0; cmt_we = 0;
    end
    #1;
    alloc = dwe && d != 0;
    check(req, "ready", ren_ready, !alloc || mcnt != 0);
    check(req, "psrc1", ren_psrc1, msmap[s1]);
    check(req, "psrc2", ren_psrc2, msmap[s2]);
    if (!alloc || mcnt != 0) begin
      check(req, "pdst", ren_pdst, alloc ? mpool[mhead] : 0);
      check(req, "pold", ren_pold, alloc ? msmap[d] : 0);
    end
    fire = rv && alloc && mcnt != 0 && !fl;
    t = mpool[mhead];
    @(posedge clk);
    if (cfree) begin
      mcmap[rob_d[rd % 256]] = rob_p[rd % 256];
      mpool[mtail] = rob_o[rd % 256];
      mtail = inc(mtail); mchead = inc(mchead); rd++;
    end
    if (fl) begin
      for (int i = 0; i < NMAP; i++) msmap[i] = mcmap[i];
      mhead = mchead; mcnt = NFREE; rd = wr;
    end else begin
      if (fire) begin
        rob_d[wr % 256] = d; rob_p[wr % 256] = t; rob_o[wr % 256] = msmap[d];
        wr++;
        msmap[d] = t; mhead = inc(mhead);
      end
      mcnt = mcnt - int'(fire) + int'(cfree);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset mapping i -> i
    for (int i = 0; i < NMAP; i++) step(0, i, NMAP - 1 - i, 0, 0, 0, 0, 0, "R1");
    // R4: zero destination allocates nothing
    step(1, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 7, 0, 0, 0, "R4");
    // R2: first grants are 33, 34 in order; R3: second write of r5 differs
    @(negedge clk); ren_dst_we = 1; ren_dst = 5; ren_valid = 0; #1;
    check("R2", "first tag", ren_pdst, 33);
    step(1, 5, 1, 1, 5, 0, 0, 0, "R2");
    step(1, 5, 5, 1, 5, 0, 0, 0, "R3");
    @(negedge clk); ren_valid = 0; ren_src1 = 5; #1;
    check("R3", "src after two writes", ren_psrc1, 34);
    // R5: flags register index 32
    step(1, 32, 0, 1, 32, 0, 0, 0, "R5");
    step(0, 32, 32, 0, 0, 0, 0, 0, "R5");
    // R8: flush restores reset map and re-grants 33
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    @(negedge clk); ren_valid = 0; ren_src1 = 5; ren_src2 = 32;
    ren_dst_we = 1; ren_dst = 9; #1;
    check("R8", "restored r5", ren_psrc1, 5);
    check("R8", "restored flags", ren_psrc2, 32);
    check("R8", "regrant", ren_pdst, 33);
    // R6: exhaust the pool
    for (int n = 0; n < NFREE; n++) step(1, n % NMAP, 0, 1, 1 + n % ARCH, 0, 0, 0, "R6");
    step(1, 1, 2, 1, 4, 0, 0, 0, "R6");
    step(1, 4, 0, 1, 4, 0, 0, 0, "R6");
    step(1, 4, 0, 0, 0, 0, 0, 0, "R6");
    // R7: commits return old tags to the tail
    for (int n = 0; n < 3; n++) step(0, 0, 0, 0, 0, 1, 0, 0, "R7");
    for (int n = 0; n < 3; n++) step(1, n, 0, 1, 10 + n, 0, 0, 0, "R7");
    // R10: non-writing commits change nothing
    for (int n = 0; n < 4; n++) step(1, 10, 11, 1, 20, 0, 1, 0, "R10");
    // R9: flush with a rename the same cycle
    step(1, 2, 3, 1, 6, 0, 0, 1, "R9");
    step(1, 6, 0, 1, 6, 0, 0, 0, "R9");
    // R8: flush with a commit the same cycle
    step(1, 6, 0, 1, 7, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R8");
    step(1, 6, 7, 1, 8, 0, 0, 0, "R8");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      step(1'($urandom % 10 < 7), $urandom % NMAP, $urandom % NMAP,
           1'($urandom % 10 < 8), $urandom % NMAP,
           1'($urandom % 10 < 4), 1'(r < 5), 1'(r == 99), "R3");
    end
    summary();
  end
endmodule